// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block joins two 8-bit data paths, each with its own parity bit. One path runs from an A side, which has separate input and output pins, to a B side. The other runs from B back to A. The B side behaves as an open-drain bus: the block only ever pulls a B line low, and an external pull-up supplies the high level. The A side outputs come with a single output-valid flag that stands in for a tri-state driver.

Each direction has its own transparent latch on its data and parity inputs. While a direction's latch enable is high, the inputs flow straight through. When the enable is low, the values captured at the last clock edge with the enable high are used instead. The latch is built as a capture flop with a combinational bypass.

A mode pin selects what is sent as the outgoing parity bit, the same way for both directions:
- in generate mode, the block computes parity from the eight data bits;
- in pass-through mode, it forwards the incoming parity bit unchanged.

In either mode, each side's incoming parity is checked against its data, and the result is reported on an active-low error flag. A single pin chooses even or odd parity for both the generator and the checker.

Top module: `par_xcvr`

## Requirements
- R1: With `oe_ab_n` low, `b_dat_lo[i]` is 1 exactly when the A-to-B data bit i in use is 0. With `oe_ba_n` low, `a_oe` is 1 and `a_dout` equals the B-to-A data in use.
- R2: A direction whose latch enable is high uses its current data and parity inputs. While the enable is low, it uses the values present at the last rising clock edge at which the enable was high, and input changes have no effect on the outputs.
- R3: With `oe_ab_n` high, every bit of `b_dat_lo` and `b_par_lo` is 0, so the bus floats high. With `oe_ba_n` high, `a_oe` is 0.
- R4: With both output enables low, both sides drive at the same time, and both error flags are computed in the same cycle.
- R5: With `pass_sel` = 1, the outgoing parity equals the incoming parity bit in use on the opposite side. On B, this is seen as `b_par_lo` = NOT that bit.
- R6: With `pass_sel` = 0, the outgoing parity is the XOR of the eight data bits in use, XORed with `odd_sel`. So with `odd_sel` = 0, an even number of ones gives 0, and with `odd_sel` = 1 it gives 1.
- R7: `err_a_n` is 0 when the A parity in use differs from the parity generated from the A data in use, and 1 when they match. `err_b_n` does the same for the B inputs. Both flags are computed for either value of `pass_sel`.
- R8: While a direction's output enable is high, its error flag keeps the last value it had while that enable was low.
- R9: After an active-low `rst_n`, both latches hold all zeros and both error flags read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch capture and error hold |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_din | input | 8 | A-side data inputs |
| a_pin | input | 1 | A-side parity input |
| a_dout | output | 8 | A-side data outputs (meaningful when `a_oe` is 1) |
| a_pout | output | 1 | A-side parity output |
| a_oe | output | 1 | A-side output drive enable |
| b_din | input | 8 | B bus data as read |
| b_pin | input | 1 | B bus parity as read |
| b_dat_lo | output | 8 | Per-bit pull-low enable for B data |
| b_par_lo | output | 1 | Pull-low enable for B parity |
| oe_ab_n | input | 1 | Active-low enable of the A-to-B path |
| oe_ba_n | input | 1 | Active-low enable of the B-to-A path |
| le_ab | input | 1 | A-to-B latch enable, transparent when high |
| le_ba | input | 1 | B-to-A latch enable, transparent when high |
| pass_sel | input | 1 | 1 forwards incoming parity, 0 generates it |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| err_a_n | output | 1 | Active-low A-side parity error |
| err_b_n | output | 1 | Active-low B-side parity error |

## Verification
The bench sweeps all 16 settings of the two enables, the mode pin and the parity-sense pin. Each setting runs against data patterns with zero, one and several set bits, and with the incoming parity both right and wrong. This exposes three kinds of fault:
- a generator or checker that ignores the parity-sense pin;
- a checker that is silenced in pass-through mode;
- a path that crosses the A and B flags.

Directed cases target the latch. After the enable falls, changed inputs must not reach the outputs, which catches a design that stays transparent. They also check the error flag hold while a path is disabled, which catches a flag that keeps tracking the inputs. Finally, they check that reset leaves zero-filled latches behind, so a design that resets to the live inputs fails.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic              par;
        logic              err_n;
    } lane_st_t;

endpackage

// File: rtl/par_xcvr_pgen.sv
module par_xcvr_pgen #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         odd_sel,
    output logic         par
);
    logic [W:0] chain;

    assign chain[0] = odd_sel;

    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ data[i];
    end

    assign par = chain[W];
endmodule

// File: rtl/par_xcvr_lane.sv
module par_xcvr_lane
    import par_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic              en,
    input  logic              pass_sel,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              pin,
    output logic [DATA_W-1:0] dat_use,
    output logic              par_out,
    output logic              err_n
);
    lane_st_t          st_d, st_q;
    logic [DATA_W-1:0] dat_sel;
    logic              par_sel;
    logic              gen_par;
    logic              err_now;

    // Transparent path when the latch is open, held copy otherwise.
    assign dat_sel = le ? din : st_q.dat;
    assign par_sel = le ? pin : st_q.par;

    par_xcvr_pgen #(.W(DATA_W)) u_pgen (
        .data    (dat_sel),
        .odd_sel (odd_sel),
        .par     (gen_par)
    );

    assign err_now = (par_sel == gen_par);

    always_comb begin
        st_d = st_q;
        if (le) begin
            st_d.dat = din;
            st_d.par = pin;
        end
        if (en) begin
            st_d.err_n = err_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dat: '0, par: 1'b0, err_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dat_use = dat_sel;
    assign par_out = pass_sel ? par_sel : gen_par;
    assign err_n   = en ? err_now : st_q.err_n;
endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
    import par_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_din,
    input  logic              a_pin,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_pout,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_din,
    input  logic              b_pin,
    output logic [DATA_W-1:0] b_dat_lo,
    output logic              b_par_lo,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              pass_sel,
    input  logic              odd_sel,
    output logic              err_a_n,
    output logic              err_b_n
);
    logic [DATA_W-1:0] ab_dat;
    logic              ab_par;
    logic [DATA_W-1:0] ba_dat;
    logic              ba_par;

    par_xcvr_lane u_ab (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (le_ab),
        .en       (~oe_ab_n),
        .pass_sel (pass_sel),
        .odd_sel  (odd_sel),
        .din      (a_din),
        .pin      (a_pin),
        .dat_use  (ab_dat),
        .par_out  (ab_par),
        .err_n    (err_a_n)
    );

    par_xcvr_lane u_ba (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (le_ba),
        .en       (~oe_ba_n),
        .pass_sel (pass_sel),
        .odd_sel  (odd_sel),
        .din      (b_din),
        .pin      (b_pin),
        .dat_use  (ba_dat),
        .par_out  (ba_par),
        .err_n    (err_b_n)
    );

    // Open-drain B side: pull low only for a 0 while enabled.
    assign b_dat_lo = {DATA_W{~oe_ab_n}} & ~ab_dat;
    assign b_par_lo = ~oe_ab_n & ~ab_par;

    assign a_oe   = ~oe_ba_n;
    assign a_dout = ba_dat;
    assign a_pout = ba_par;
endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk
    import par_xcvr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_din,
    input logic              a_pin,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_pout,
    input logic              a_oe,
    input logic [DATA_W-1:0] b_din,
    input logic              b_pin,
    input logic [DATA_W-1:0] b_dat_lo,
    input logic              b_par_lo,
    input logic              oe_ab_n,
    input logic              oe_ba_n,
    input logic              le_ab,
    input logic              le_ba,
    input logic              pass_sel,
    input logic              odd_sel,
    input logic              err_a_n,
    input logic              err_b_n
);
    p_b_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ab_n |-> (b_dat_lo == '0 && !b_par_lo));

    p_a_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ba_n |-> !a_oe);

    p_ab_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && le_ab) |-> (b_dat_lo == ~a_din));

    p_ba_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ba_n && le_ba) |-> (a_dout == b_din));

    p_ab_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && le_ab && !pass_sel) |-> (b_par_lo == !(^a_din ^ odd_sel)));

    p_ab_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && le_ab && pass_sel) |-> (b_par_lo == !a_pin));

    p_err_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && le_ab) |-> (err_a_n == (a_pin == (^a_din ^ odd_sel))));

    p_err_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ba_n && le_ba) |-> (err_b_n == (b_pin == (^b_din ^ odd_sel))));

    p_hold_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && $past(!le_ab) && $stable(oe_ab_n) && $stable(pass_sel)
         && $stable(odd_sel)) |-> ($stable(b_dat_lo) && $stable(b_par_lo)));

    p_err_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ab_n && $past(oe_ab_n)) |-> $stable(err_a_n));

    p_err_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ba_n && $past(oe_ba_n)) |-> $stable(err_b_n));
endmodule

bind par_xcvr par_xcvr_chk chk_i (.*);

// File: tb/par_xcvr_tb_top.sv
module par_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] a_din, b_din, a_dout, b_dat_lo;
    logic       a_pin, b_pin, a_pout, a_oe, b_par_lo;
    logic       oe_ab_n, oe_ba_n, le_ab, le_ba, pass_sel, odd_sel;
    logic       err_a_n, err_b_n;
    int         n_vec = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    par_xcvr dut_i (.*);

    // {even-parity bit, data}; parity bit worked out by hand per pattern
    localparam logic [8:0] VEC [0:7] = '{
        {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h01}, {1'b1, 8'h80},
        {1'b0, 8'hA5}, {1'b0, 8'h7E}, {1'b1, 8'h3B}, {1'b1, 8'hC4}
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200_000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_din = 8'h5A; b_din = 8'h3C; a_pin = 1'b1; b_pin = 1'b1;
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; le_ab = 1'b0; le_ba = 1'b0;
        pass_sel = 1'b0; odd_sel = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R9: zero-filled latches with enables low; the live inputs are ignored
        chk("R9 a_dout", {1'b0, a_dout}, 9'h000);
        chk("R9 b_dat_lo", {1'b0, b_dat_lo}, 9'h0FF);
        chk("R9 b_par_lo", {8'h0, b_par_lo}, 9'h001);
        chk("R9 a_pout", {8'h0, a_pout}, 9'h000);
        chk("R9 err flags", {7'h0, err_a_n, err_b_n}, 9'h003);

        // Sweep of every control combination (R1 R3 R4 R5 R6 R7)
        le_ab = 1'b1; le_ba = 1'b1;
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 8; k++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [8:0] va, vb;
                    logic ga, gb, ea, eb;
                    va = VEC[k]; vb = VEC[(k + 3) % 8];
                    {oe_ab_n, oe_ba_n, pass_sel, odd_sel} = 4'(c);
                    a_din = va[7:0]; a_pin = p[0];
                    b_din = vb[7:0]; b_pin = ~p[0];
                    tick();
                    ga = va[8] ^ odd_sel;
                    gb = vb[8] ^ odd_sel;
                    ea = pass_sel ? a_pin : ga;
                    eb = pass_sel ? b_pin : gb;
                    if (oe_ab_n) begin
                        chk("R3 b float", {b_par_lo, b_dat_lo}, 9'h000);
                    end else begin
                        chk("R1 b data", {1'b0, b_dat_lo}, {1'b0, ~va[7:0]});
                        chk(pass_sel ? "R5 b parity" : "R6 b parity",
                            {8'h0, b_par_lo}, {8'h0, ~ea});
                        chk("R7 err_a_n", {8'h0, err_a_n}, {8'h0, a_pin == ga});
                    end
                    chk("R3 a_oe", {8'h0, a_oe}, {8'h0, ~oe_ba_n});
                    if (!oe_ba_n) begin
                        chk("R1 a data", {1'b0, a_dout}, {1'b0, vb[7:0]});
                        chk(pass_sel ? "R5 a parity" : "R6 a parity",
                            {8'h0, a_pout}, {8'h0, eb});
                        chk("R7 err_b_n", {8'h0, err_b_n}, {8'h0, b_pin == gb});
                    end
                    if (!oe_ab_n && !oe_ba_n) begin
                        chk("R4 both flags", {7'h0, err_a_n, err_b_n},
                            {7'h0, a_pin == ga, b_pin == gb});
                    end
                end
            end
        end

        // R2: capture 8'h3B (odd count) then close latch and change inputs
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; pass_sel = 1'b0; odd_sel = 1'b0;
        le_ab = 1'b1; le_ba = 1'b1;
        a_din = 8'h3B; a_pin = 1'b1; b_din = 8'hA5; b_pin = 1'b0;
        tick();
        le_ab = 1'b0; le_ba = 1'b0;
        a_din = 8'hFF; a_pin = 1'b0; b_din = 8'h01; b_pin = 1'b1;
        tick();
        chk("R2 held b data", {1'b0, b_dat_lo}, {1'b0, ~8'h3B});
        chk("R2 held b parity", {8'h0, b_par_lo}, 9'h000);
        chk("R2 held a data", {1'b0, a_dout}, 9'h0A5);
        chk("R2 held flags", {7'h0, err_a_n, err_b_n}, 9'h003);
        pass_sel = 1'b1;
        tick();
        chk("R2 R5 held parity pass", {7'h0, b_par_lo, a_pout}, 9'h000);

        // R8: register an A error, then disable and present a matching input
        pass_sel = 1'b0; le_ab = 1'b1;
        a_din = 8'h01; a_pin = 1'b0;
        tick();
        chk("R7 err_a_n low", {8'h0, err_a_n}, 9'h000);
        oe_ab_n = 1'b1; a_pin = 1'b1;
        tick(); tick();
        chk("R8 err_a_n held", {8'h0, err_a_n}, 9'h000);
        oe_ab_n = 1'b0;
        tick();
        chk("R8 err_a_n after re-enable", {8'h0, err_a_n}, 9'h001);

        // R8 for the B side
        le_ba = 1'b1; b_din = 8'h00; b_pin = 1'b1;
        tick();
        chk("R7 err_b_n low", {8'h0, err_b_n}, 9'h000);
        oe_ba_n = 1'b1; b_pin = 1'b0;
        tick(); tick();
        chk("R8 err_b_n held", {8'h0, err_b_n}, 9'h000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule